// File: doc/BRIEF.md
# Sanitize Pass Sequencer

This block runs a destructive clean-up routine over a range of flash blocks. It is built from up to three steps. Each step is picked by a 2-bit code and either only erases each block or erases it and then overwrites it with one of two fill bytes. The first step can be repeated a programmable number of times. The block drives a one-at-a-time erase/program request port that a flash back end accepts with a ready signal. A program request carries the block number and the fill byte, and the back end writes that byte to every byte of the block.

A start pulse latches the configuration. The sequencer can take it from the explicit inputs, from a built-in three-pass preset, or from a default single erase pass. When the routine ends, the block pulses done and enters a terminal locked state. In that state it stays quiet and refuses every later start until reset.

Top module: `sanitize_seq`

## Requirements
- R1: After reset, req_valid, busy, done, locked and refused are all 0.
- R2: Step codes are 01 for erase only, 10 for erase then overwrite with fill A, and 11 for erase then overwrite with fill B. Code 00 means no step and ends the chain there. If step 0 is 00, done pulses with no request issued.
- R3: Each step handles blocks 0 to N-1 in ascending order before the next step starts. For overwrite steps, the program request for a block (req_is_prog=1) directly follows that block's accepted erase request (req_is_prog=0).
- R4: A range size of 0 on blk_count means 2^BLK_W blocks.
- R5: Step 0 runs rpt_cnt+1 times in total. A count of 0 runs it once.
- R6: With cfg_en=0 and preset_en=0, one erase-only pass is run over the range. The op, fill and count inputs have no effect.
- R7: When preset_en=1 (it takes priority over cfg_en), the steps are: erase plus fill 0x55, then erase plus fill 0xAA, then erase. Each step runs once.
- R8: A request that has not yet been accepted holds its valid, block, type and data stable.
- R9: When the routine completes, done is high for exactly one cycle, locked goes high and stays high, and busy drops.
- R10: While locked, no request is issued. A start pulse is refused, and refused is high for one cycle in the cycle after the start.
- R11: Start is sampled only when idle. A start during a run has no effect on the running routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin routine (one-cycle pulse) |
| cfg_en | input | 1 | Use the explicit step codes, fills and count |
| preset_en | input | 1 | Use the built-in three-pass preset |
| op0 | input | 2 | Step 0 code |
| op1 | input | 2 | Step 1 code |
| op2 | input | 2 | Step 2 code |
| fill_a | input | 8 | Fill byte for code 10 |
| fill_b | input | 8 | Fill byte for code 11 |
| rpt_cnt | input | CNT_W | Extra repeats of step 0 |
| blk_count | input | BLK_W | Blocks in range, 0 = 2^BLK_W |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Back end accepts request |
| req_is_prog | output | 1 | 1 = program (fill), 0 = erase |
| req_blk | output | BLK_W | Target block |
| req_data | output | 8 | Fill byte for program requests, 0 otherwise |
| busy | output | 1 | Routine in progress |
| done | output | 1 | Completion pulse |
| locked | output | 1 | Terminal state reached |
| refused | output | 1 | A start was refused while locked |

## Verification
On every cycle, the assertions check the hold-while-stalled rule, that locked is permanent and silent, that done is a single-cycle pulse, and that each program request follows an accepted erase of the same block. Request counts, fill-byte sums, the order of blocks across steps, the repeat rule, the no-step early end, the preset and default choices, and the refusal of starts (both during a run and after lockout) can only be shown by the bench scenarios. Those scenarios run with and without back-end stalls.

// File: rtl/sanitize_seq.sv
module sanitize_seq #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_en,
  input  logic             preset_en,
  input  logic [1:0]       op0,
  input  logic [1:0]       op1,
  input  logic [1:0]       op2,
  input  logic [7:0]       fill_a,
  input  logic [7:0]       fill_b,
  input  logic [CNT_W-1:0] rpt_cnt,
  input  logic [BLK_W-1:0] blk_count,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_is_prog,
  output logic [BLK_W-1:0] req_blk,
  output logic [7:0]       req_data,
  output logic             busy,
  output logic             done,
  output logic             locked,
  output logic             refused
);

  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_ER   = 2'd1;
  localparam logic [1:0] OP_FA   = 2'd2;
  localparam logic [1:0] OP_FB   = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG, S_LOCK} state_t;

  state_t           state;
  logic [7:0]       ops_q;
  logic [7:0]       pa_q, pb_q;
  logic [CNT_W-1:0] rep_q;
  logic [BLK_W-1:0] blk_q, last_q;
  logic [1:0]       step_q;
  logic             done_q, refused_q;

  logic [7:0]       load_ops, load_pa, load_pb;
  logic [CNT_W-1:0] load_rep;
  logic [1:0]       cur_op, next_op;
  logic             handshake, blk_done, last_blk, repeat_now;

  always_comb begin
    if (preset_en) begin
      load_ops = {OP_NONE, OP_ER, OP_FB, OP_FA};
      load_pa  = 8'h55;
      load_pb  = 8'hAA;
      load_rep = '0;
    end else if (cfg_en) begin
      load_ops = {OP_NONE, op2, op1, op0};
      load_pa  = fill_a;
      load_pb  = fill_b;
      load_rep = rpt_cnt;
    end else begin
      load_ops = {OP_NONE, OP_NONE, OP_NONE, OP_ER};
      load_pa  = '0;
      load_pb  = '0;
      load_rep = '0;
    end
  end

  assign cur_op     = ops_q[{step_q, 1'b0} +: 2];
  assign next_op    = ops_q[{step_q + 2'd1, 1'b0} +: 2];
  assign handshake  = req_valid && req_ready;
  assign blk_done   = handshake && (state == S_PROG || (state == S_ERASE && !cur_op[1]));
  assign last_blk   = (blk_q == last_q);
  assign repeat_now = (step_q == 2'd0) && (rep_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ops_q     <= '0;
      pa_q      <= '0;
      pb_q      <= '0;
      rep_q     <= '0;
      blk_q     <= '0;
      last_q    <= '0;
      step_q    <= '0;
      done_q    <= 1'b0;
      refused_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      refused_q <= start && (state == S_LOCK);
      case (state)
        S_IDLE: if (start) begin
          ops_q  <= load_ops;
          pa_q   <= load_pa;
          pb_q   <= load_pb;
          rep_q  <= load_rep;
          last_q <= blk_count - BLK_W'(1);
          blk_q  <= '0;
          step_q <= '0;
          if (load_ops[1:0] == OP_NONE) begin
            state  <= S_LOCK;
            done_q <= 1'b1;
          end else begin
            state <= S_ERASE;
          end
        end
        S_ERASE, S_PROG: begin
          if (blk_done) begin
            if (!last_blk) begin
              blk_q <= blk_q + BLK_W'(1);
              state <= S_ERASE;
            end else begin
              blk_q <= '0;
              if (repeat_now) begin
                rep_q <= rep_q - CNT_W'(1);
                state <= S_ERASE;
              end else if (next_op == OP_NONE) begin
                state  <= S_LOCK;
                done_q <= 1'b1;
              end else begin
                step_q <= step_q + 2'd1;
                state  <= S_ERASE;
              end
            end
          end else if (state == S_ERASE && handshake) begin
            state <= S_PROG;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_valid   = (state == S_ERASE) || (state == S_PROG);
  assign req_is_prog = (state == S_PROG);
  assign req_blk     = blk_q;
  assign req_data    = !req_is_prog ? 8'h00 : (cur_op == OP_FA) ? pa_q : pb_q;
  assign busy        = req_valid;
  assign locked      = (state == S_LOCK);
  assign done        = done_q;
  assign refused     = refused_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_blk) && $stable(req_is_prog) && $stable(req_data));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R10
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !req_valid && !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && locked);

  // R3
  prog_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_is_prog && !$past(req_valid && req_is_prog)
      |-> $past(req_valid && req_ready && !req_is_prog) && (req_blk == $past(req_blk)));

endmodule

// File: tb/sim_sanitize_seq.sv
module sim_sanitize_seq;
  localparam int CLK_P = 10;
  localparam int BLK_W = 4;
  localparam int CNT_W = 4;
  localparam int VW = 80;
  localparam int NV = 6;
  // {preset, cfg, op0, op1, op2, fill_a, fill_b, cnt, nblk, erases, progs, fill_sum}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd3, 2'd3, 2'd3, 8'h77, 8'h66, 4'd3, 4'd5, 16'd5,  16'd0,  16'd0},
    {1'b1, 1'b1, 2'd1, 2'd1, 2'd1, 8'h01, 8'h02, 4'd7, 4'd3, 16'd9,  16'd6,  16'd765},
    {1'b0, 1'b1, 2'd2, 2'd0, 2'd3, 8'h12, 8'h34, 4'd2, 4'd4, 16'd12, 16'd12, 16'd216},
    {1'b0, 1'b1, 2'd1, 2'd3, 2'd1, 8'h00, 8'h0F, 4'd0, 4'd0, 16'd48, 16'd16, 16'd240},
    {1'b0, 1'b1, 2'd0, 2'd2, 2'd1, 8'h11, 8'h22, 4'd5, 4'd3, 16'd0,  16'd0,  16'd0},
    {1'b0, 1'b1, 2'd3, 2'd2, 2'd2, 8'h01, 8'h02, 4'd1, 4'd1, 16'd4,  16'd4,  16'd6}
  };
  localparam string VREQ [NV] = '{"R6", "R7", "R5", "R4", "R2", "R5"};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_en = 1'b0, preset_en = 1'b0;
  logic [1:0] op0 = '0, op1 = '0, op2 = '0;
  logic [7:0] fill_a = '0, fill_b = '0;
  logic [CNT_W-1:0] rpt_cnt = '0;
  logic [BLK_W-1:0] blk_count = '0;
  logic req_valid, req_ready = 1'b1, req_is_prog, busy, done, locked, refused;
  logic [BLK_W-1:0] req_blk;
  logic [7:0] req_data;
  logic [7:0] lfsr = 8'hA5;
  logic stall_en = 1'b0;

  int checks = 0, failures = 0, cyc = 0;
  logic wd = 1'b0;
  int er_n, pr_n, sum, done_n, ref_n, nblk_eff, exp_blk, last_er;
  logic order_bad, erase_pending;

  sanitize_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_en(cfg_en), .preset_en(preset_en),
    .op0(op0), .op1(op1), .op2(op2), .fill_a(fill_a), .fill_b(fill_b),
    .rpt_cnt(rpt_cnt), .blk_count(blk_count), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_prog(req_is_prog), .req_blk(req_blk), .req_data(req_data),
    .busy(busy), .done(done), .locked(locked), .refused(refused));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) wd <= 1'b1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (done) done_n = done_n + 1;
    if (refused) ref_n = ref_n + 1;
    if (req_valid && req_ready) begin
      if (!req_is_prog) begin
        er_n = er_n + 1;
        if (int'(req_blk) != exp_blk) order_bad = 1'b1;
        last_er = int'(req_blk);
        exp_blk = (int'(req_blk) + 1) % nblk_eff;
        erase_pending = 1'b1;
      end else begin
        pr_n = pr_n + 1;
        sum = sum + int'(req_data);
        if (!erase_pending || int'(req_blk) != last_er) order_bad = 1'b1;
        erase_pending = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_mon(input int n);
    er_n = 0; pr_n = 0; sum = 0; done_n = 0; ref_n = 0;
    nblk_eff = n; exp_blk = 0; last_er = -1;
    order_bad = 1'b0; erase_pending = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_lock();
    while (!locked && !wd) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(!req_valid && !busy && !done && !locked && !refused, "R1",
        {req_valid, busy, done, locked, refused}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      do_reset();
      stall_en = v[0];
      clear_mon((e[51:48] == 4'd0) ? 16 : int'(e[51:48]));
      preset_en = e[79]; cfg_en = e[78];
      op0 = e[77:76]; op1 = e[75:74]; op2 = e[73:72];
      fill_a = e[71:64]; fill_b = e[63:56]; rpt_cnt = e[55:52]; blk_count = e[51:48];
      pulse_start();
      wait_lock();
      chk(er_n == int'(e[47:32]), VREQ[v], er_n, int'(e[47:32]));
      chk(pr_n == int'(e[31:16]), VREQ[v], pr_n, int'(e[31:16]));
      chk(sum == int'(e[15:0]), "R2", sum, int'(e[15:0]));
      chk(!order_bad, "R3", order_bad, 0);
      chk(done_n == 1, "R9", done_n, 1);
      chk(locked && !busy, "R9", {locked, busy}, 2);
    end

    // R11: start during a run is ignored
    do_reset();
    stall_en = 1'b1;
    clear_mon(8);
    preset_en = 1'b0; cfg_en = 1'b1; op0 = 2'd1; op1 = 2'd0; op2 = 2'd0;
    rpt_cnt = '0; blk_count = 4'd8;
    pulse_start();
    repeat (3) @(posedge clk);
    #1 preset_en = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0; preset_en = 1'b0;
    wait_lock();
    chk(er_n == 8, "R11", er_n, 8);
    chk(pr_n == 0, "R11", pr_n, 0);

    // R10: start after lockout is refused
    clear_mon(8);
    cfg_en = 1'b1; op0 = 2'd3; fill_b = 8'hC3;
    pulse_start();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(er_n == 0 && pr_n == 0, "R10", er_n + pr_n, 0);
    chk(ref_n == 1, "R10", ref_n, 1);
    chk(locked && !busy && done_n == 0, "R10", {locked, busy}, 2);

    if (wd) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (wd);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule